// File: doc/BRIEF.md
# Elapsed-Seconds Counter Register File

This block keeps the elapsed-time state of a real-time clock as a 32-bit binary seconds count. A host reaches the count, one control byte and one stored charger-setup byte through a byte-wide port with request, write-enable, address and data. A one-second tick from the oscillator domain advances the count. Bit 7 of the control byte is an active-low oscillator enable: while it is 1 the count stands still.

A power-fail input locks the host out. A write made while it is high changes nothing. A read made while it is high returns 00h and raises a reject flag. The count keeps running from ticks during this time. A backup-mode input decides whether a set stop bit only freezes the count, with the oscillator still running on main power, or also switches the oscillator off for low-power standby in backup mode. The block reports that choice on its oscillator-run output.

Top module: `epoch_rtc_regs`

## Requirements
- R1: After the asynchronous reset, the count is 0, the control byte is 00h and the charger byte is 00h. Reads of addresses 00h to 05h return 00h, reject_o is 0 and osc_run_o is 1.
- R2: Address 00h holds count bits 7:0, 01h holds bits 15:8, 02h holds bits 23:16 and 03h holds bits 31:24. Each count byte can be written and read back.
- R3: Each cycle with tick_i high, with control bit 7 at 0 and with no accepted count write adds exactly one to the count.
- R4: While control bit 7 is 1, ticks do not change the count. If backup_i is 0, osc_run_o stays 1.
- R5: osc_run_o is 0 exactly when backup_i is 1 and control bit 7 is 1. With bit 7 at 0, ticks still count while backup_i is 1.
- R6: While pwr_fail_i is 1, a request is rejected. A rejected write changes no register. A rejected read gives rdata_o = 00h. In both cases reject_o is 1 in the cycle after the request. Register contents are kept, and ticks still count.
- R7: Addresses 06h and above read as 00h, ignore writes and are not rejected.
- R8: An accepted count-byte write in the same cycle as an enabled tick loads the written byte. The other count bytes keep their pre-tick value, and the tick is lost.
- R9: The count wraps from FFFFFFFFh to 00000000h on an enabled tick.
- R10: The charger byte at 05h stores all 8 bits: select field in bits 7:4, diode field in bits 3:2 and resistor field in bits 1:0. It reads back unchanged.
- R11: The control byte at 04h keeps only bit 7. Bits 6:0 read as 0.
- R12: A read request returns the register value of its request cycle on rdata_o one cycle later. In a cycle after no accepted read, rdata_o is 00h, and reject_o is 0 unless a request was rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| backup_i | input | 1 | High while running from the backup supply |
| pwr_fail_i | input | 1 | High while main power is below the write-protect level |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the request |
| reject_o | output | 1 | Request of the previous cycle was blocked by power fail |
| osc_run_o | output | 1 | Oscillator run request to the analog side |

## Verification
Directed sequences cover each case on its own: distinct byte patterns that expose swapped byte lanes, a carry across all four bytes into wrap, and a write that collides with a tick so that a lost tick can be told from a counted one. They also cover every combination of the stop bit and backup mode, which separates "frozen count" from "oscillator off". A random phase with a fixed seed then mixes ticks, power-fail windows, backup toggles, out-of-range addresses and writes to the control byte. In that phase, every cycle's rdata_o, reject_o and osc_run_o is compared with a bench model. The model exposes races between a control write and a same-cycle tick, and lockouts that leak state.

// File: rtl/epoch_rtc_pkg.sv
package epoch_rtc_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned OSC_STOP_BIT = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CHG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtc_host_gate.sv
module rtc_host_gate (
  input  logic req_i,
  input  logic we_i,
  input  logic pwr_fail_i,
  output logic wr_ok_o,
  output logic rd_ok_o,
  output logic reject_o
);
  always_comb begin
    wr_ok_o  = req_i &&  we_i && !pwr_fail_i;
    rd_ok_o  = req_i && !we_i && !pwr_fail_i;
    reject_o = req_i &&  pwr_fail_i;
  end
endmodule

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
  import epoch_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_BYTES = 4,
  localparam int unsigned IDX_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output reg_sel_e             sel_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [CNT_BYTES-1:0] cnt_oh_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] CHG_ADDR  = ADDR_W'(CNT_BYTES + 1);

  always_comb begin
    if (addr_i < CTRL_ADDR)       sel_o = SEL_CNT;
    else if (addr_i == CTRL_ADDR) sel_o = SEL_CTRL;
    else if (addr_i == CHG_ADDR)  sel_o = SEL_CHG;
    else                          sel_o = SEL_NONE;
    idx_o = addr_i[IDX_W-1:0];
  end

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_oh
    assign cnt_oh_o[b] = (addr_i == ADDR_W'(b));
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import epoch_rtc_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 4,
  localparam int unsigned CNT_W    = CNT_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_en_i,
  input  logic [CNT_BYTES-1:0] wr_oh_i,
  input  byte_t                wdata_i,
  output logic [CNT_W-1:0]     count_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val;

  // byte merge: written lane takes host data, others keep pre-tick value
  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
    assign load_val[b*BYTE_W +: BYTE_W] =
      wr_oh_i[b] ? wdata_i : count_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (|wr_oh_i)  count_q <= load_val;
    else if (tick_en_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import epoch_rtc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_we_i,
  input  logic  chg_we_i,
  input  byte_t wdata_i,
  output logic  osc_stop_o,
  output byte_t chg_o
);
  logic  stop_q;
  byte_t chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      chg_q  <= '0;
    end else begin
      if (ctrl_we_i) stop_q <= wdata_i[OSC_STOP_BIT];
      if (chg_we_i)  chg_q  <= wdata_i;
    end
  end

  assign osc_stop_o = stop_q;
  assign chg_o      = chg_q;
endmodule

// File: rtl/epoch_rtc_regs.sv
module epoch_rtc_regs
  import epoch_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              backup_i,
  input  logic              pwr_fail_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              reject_o,
  output logic              osc_run_o
);
  localparam int unsigned CNT_W = CNT_BYTES * BYTE_W;
  localparam int unsigned IDX_W = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;

  logic                 wr_ok, rd_ok, rej;
  reg_sel_e             sel;
  logic [IDX_W-1:0]     idx;
  logic [CNT_BYTES-1:0] cnt_oh;
  logic [CNT_BYTES-1:0] cnt_wr_oh;
  logic [CNT_W-1:0]     count_q;
  logic                 osc_stop;
  byte_t                chg;
  byte_t                cnt_byte [CNT_BYTES];
  byte_t                rd_mux;
  byte_t                rdata_q;
  logic                 reject_q;

  rtc_host_gate u_gate (
    .req_i      (req_i),
    .we_i       (we_i),
    .pwr_fail_i (pwr_fail_i),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .reject_o   (rej)
  );

  rtc_addr_dec #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_dec (
    .addr_i   (addr_i),
    .sel_o    (sel),
    .idx_o    (idx),
    .cnt_oh_o (cnt_oh)
  );

  assign cnt_wr_oh = (wr_ok && sel == SEL_CNT) ? cnt_oh : '0;

  rtc_sec_counter #(.CNT_BYTES(CNT_BYTES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_i && !osc_stop),
    .wr_oh_i   (cnt_wr_oh),
    .wdata_i   (wdata_i),
    .count_o   (count_q)
  );

  rtc_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr_ok && sel == SEL_CTRL),
    .chg_we_i   (wr_ok && sel == SEL_CHG),
    .wdata_i    (wdata_i),
    .osc_stop_o (osc_stop),
    .chg_o      (chg)
  );

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_rd
    assign cnt_byte[b] = count_q[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (sel)
      SEL_CNT:  rd_mux = cnt_byte[idx];
      SEL_CTRL: rd_mux = byte_t'(osc_stop) << OSC_STOP_BIT;
      SEL_CHG:  rd_mux = chg;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      reject_q <= 1'b0;
    end else begin
      rdata_q  <= rd_ok ? rd_mux : '0;
      reject_q <= rej;
    end
  end

  assign rdata_o   = rdata_q;
  assign reject_o  = reject_q;
  assign osc_run_o = !(backup_i && osc_stop);
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             backup_i,
  input logic             pwr_fail_i,
  input logic             req_i,
  input logic [7:0]       rdata_o,
  input logic             reject_o,
  input logic             osc_run_o,
  input logic             osc_stop,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count_q
);
  a_r6_reject_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && pwr_fail_i |=> reject_o && rdata_o == 8'h00);

  a_r6_count_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i && !tick_i |=> $stable(count_q));

  a_r3_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !osc_stop && !cnt_wr |=> count_q == $past(count_q) + CNT_W'(1));

  a_r4_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop && !cnt_wr |=> $stable(count_q));

  a_r5_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_i && osc_stop |-> !osc_run_o);

  a_r5_osc_on_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !backup_i |-> osc_run_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> rdata_o == 8'h00 && !reject_o);
endmodule

bind epoch_rtc_regs rtc_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .backup_i   (backup_i),
  .pwr_fail_i (pwr_fail_i),
  .req_i      (req_i),
  .rdata_o    (rdata_o),
  .reject_o   (reject_o),
  .osc_run_o  (osc_run_o),
  .osc_stop   (osc_stop),
  .cnt_wr     (|cnt_wr_oh),
  .count_q    (count_q)
);

// File: tb/epoch_rtc_regs_tb_top.sv
module epoch_rtc_regs_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, bk = 1'b0, pf = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       reject, osc_run;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cnt = '0;
  logic [7:0]  m_ctrl = '0;
  logic [7:0]  m_chg = '0;

  always #(CLK_P/2) clk = ~clk;

  epoch_rtc_regs dut_i (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .backup_i (bk),
    .pwr_fail_i (pf), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .reject_o (reject), .osc_run_o (osc_run)
  );

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a < 4)       return m_cnt[a*8 +: 8];
    else if (a == 4) return m_ctrl & 8'h80;
    else if (a == 5) return m_chg;
    else             return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge, update the model, check at the next negedge
  task automatic cyc(input logic rq, input logic w, input logic [3:0] a,
                     input logic [7:0] wd, input logic tk, input string tag);
    logic [7:0] e_rd;
    logic       e_rej, inc;
    req = rq; we = w; addr = a; wdata = wd; tick = tk;
    e_rd  = (rq && !w && !pf) ? m_read(a) : 8'h00;
    e_rej = rq && pf;
    inc   = tk && !m_ctrl[7];
    @(posedge clk);
    if (rq && w && !pf && a < 4) m_cnt[a*8 +: 8] = wd;
    else begin
      if (inc) m_cnt = m_cnt + 1;
      if (rq && w && !pf && a == 4) m_ctrl = wd & 8'h80;
      if (rq && w && !pf && a == 5) m_chg = wd;
    end
    @(negedge clk);
    chk({tag, " rdata"}, rdata, e_rd);
    chk({tag, " reject"}, reject, e_rej);
    chk({tag, " osc_run"}, osc_run, !(bk && m_ctrl[7]));
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic tk(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #(CLK_P * 2 + 1);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset reject", reject, 1'b0);
    chk("R1 reset osc_run", osc_run, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) rd(4'(a), "R1");

    // R2 lane layout
    wr(4'h0, 8'h11, "R2"); wr(4'h1, 8'h22, "R2");
    wr(4'h2, 8'h33, "R2"); wr(4'h3, 8'h44, "R2");
    for (int a = 0; a < 4; a++) rd(4'(a), "R2");

    // R3 counting, including a carry out of byte 0
    wr(4'h0, 8'hFE, "R3");
    tk(3, "R3");
    for (int a = 0; a < 4; a++) rd(4'(a), "R3");

    // R12 idle and back-to-back reads
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, "R12");
    rd(4'h0, "R12"); rd(4'h1, "R12");

    // R4 stop on main power
    wr(4'h4, 8'h80, "R4");
    tk(4, "R4");
    rd(4'h0, "R4"); rd(4'h4, "R4");

    // R5 backup: stop bit turns oscillator off, clear bit keeps counting
    bk = 1'b1;
    tk(2, "R5");
    wr(4'h4, 8'h00, "R5");
    tk(3, "R5");
    rd(4'h0, "R5");
    bk = 1'b0;

    // R11 control bit mask
    wr(4'h4, 8'h7F, "R11"); rd(4'h4, "R11");
    wr(4'h4, 8'hFF, "R11"); rd(4'h4, "R11");
    wr(4'h4, 8'h00, "R11"); rd(4'h4, "R11");

    // R10 charger fields
    wr(4'h5, 8'hA5, "R10"); rd(4'h5, "R10");
    wr(4'h5, 8'h5A, "R10"); rd(4'h5, "R10");

    // R6 power-fail lockout, count keeps running
    pf = 1'b1;
    wr(4'h0, 8'h99, "R6"); wr(4'h5, 8'h00, "R6"); wr(4'h4, 8'h80, "R6");
    rd(4'h0, "R6");
    tk(2, "R6");
    pf = 1'b0;
    rd(4'h0, "R6"); rd(4'h4, "R6"); rd(4'h5, "R6");

    // R7 out-of-range addresses
    for (int a = 6; a < 16; a++) begin
      wr(4'(a), 8'hC3, "R7");
      rd(4'(a), "R7");
    end

    // R8 write colliding with a tick
    cyc(1'b1, 1'b1, 4'h1, 8'h77, 1'b1, "R8");
    for (int a = 0; a < 4; a++) rd(4'(a), "R8");

    // R9 wrap
    for (int a = 0; a < 4; a++) wr(4'(a), 8'hFF, "R9");
    tk(1, "R9");
    for (int a = 0; a < 4; a++) rd(4'(a), "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic       rq, w, t;
      logic [3:0] a;
      if ($urandom % 16 == 0) pf = ~pf;
      if ($urandom % 32 == 0) bk = ~bk;
      rq = ($urandom % 8) < 5;
      w  = ($urandom % 3) == 0;
      a  = 4'($urandom % 8);
      t  = ($urandom % 2) == 1;
      cyc(rq, w, a, 8'($urandom), t, "RND");
    end
    pf = 1'b0;
    for (int a = 0; a < 6; a++) rd(4'(a), "RND final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule